// File: doc/BRIEF.md
# Bus Cycle Command Strobe Decoder

This block sits beside a processor whose bus tells what it is doing through three lines: an active-low address strobe, a direction line and a space-select line. It turns those lines into the four separate active-low command strobes that older memory and peripheral devices expect. The four strobes are memory read, memory write, I/O read and I/O write.

A cycle opens on a rising clock edge at which the address strobe is sampled low while no cycle is open. On that edge the direction and space lines are captured. From then on the captured pair alone picks which strobe is driven low. The strobe stays low through any number of wait states. It is released on the edge at which the active-low ready input is sampled low. Only non-pipelined cycles are handled.

A parameter chooses how the strobes are produced. They can come straight from flops, which keeps them free of glitches, or they can be decoded from the cycle state. The timing at the ports is the same in both variants.

Top module: `bus_cmd_decoder`

## Requirements
- R1: While `rst_n` is low, and after its release until a cycle opens, all four strobes are high.
- R2: A cycle opened with `wr_rd`=0 and `mem_io`=1 drives `mem_rd_n` low from the opening edge, and the other three strobes stay high.
- R3: A cycle opened with `wr_rd`=1 and `mem_io`=1 drives `mem_wr_n` low, and only that strobe.
- R4: A cycle opened with `wr_rd`=0 and `mem_io`=0 drives `io_rd_n` low, and only that strobe.
- R5: A cycle opened with `wr_rd`=1 and `mem_io`=0 drives `io_wr_n` low, and only that strobe.
- R6: The selected strobe stays low for every edge at which `rdy_n` is sampled high. A strobe that opens with N such wait edges is low for N+1 clock periods. Changes on `wr_rd` or `mem_io` after the opening edge do not alter it.
- R7: The strobe goes high right after the edge at which `rdy_n` is sampled low while a cycle is open.
- R8: `ads_n` sampled low while a cycle is open is ignored, including on the completing edge. It starts no second cycle and changes no strobe.
- R9: At most one of the four strobes is low at any time.
- R10: With no cycle open, `rdy_n` low and changes on `wr_rd` and `mem_io` leave all strobes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ads_n | input | 1 | Active-low address strobe that opens a cycle |
| wr_rd | input | 1 | Direction: 1 = write, 0 = read |
| mem_io | input | 1 | Space: 1 = memory, 0 = I/O |
| rdy_n | input | 1 | Active-low ready that ends the open cycle |
| mem_rd_n | output | 1 | Active-low memory read strobe |
| mem_wr_n | output | 1 | Active-low memory write strobe |
| io_rd_n | output | 1 | Active-low I/O read strobe |
| io_wr_n | output | 1 | Active-low I/O write strobe |

## Verification
The address strobe and the ready input can both be sampled low on the same edge. This happens when a cycle completes and a new request is already presented. The bench provokes this by holding `ads_n` low on the completing edge, and also once in the middle of a wait-state stretch. It judges the result with a scoreboard: each completed strobe pulse must match one queued cycle in both strobe identity and length, and no unqueued pulse may appear. A spurious second cycle would show up as an extra pulse or a lengthened pulse.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
   localparam int NUM_CMD = 4;
   localparam int CMD_W   = $clog2(NUM_CMD);

   // index is {space, direction}: space 1 = memory, direction 1 = write
   typedef enum logic [CMD_W-1:0] {
      CMD_IORD = 2'b00,
      CMD_IOWR = 2'b01,
      CMD_MRD  = 2'b10,
      CMD_MWR  = 2'b11
   } bcd_cmd_e;
endpackage

// File: rtl/bcd_cycle_ctl.sv
module bcd_cycle_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic ads_n,
   input  logic rdy_n,
   output logic start,
   output logic finish,
   output logic active_q,
   output logic active_nxt
);
   assign start  = !active_q && !ads_n;
   assign finish = active_q && !rdy_n;

   always_comb begin
      active_nxt = active_q;
      if (start)       active_nxt = 1'b1;
      else if (finish) active_nxt = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_q <= 1'b0;
      else        active_q <= active_nxt;
   end

   // R2: a sampled address strobe with no open cycle opens one
   assert_open_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && !ads_n) |=> active_q);

   // R7: ready sampled low closes the cycle, whatever ads_n does
   assert_close_on_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !rdy_n) |=> !active_q);

   // R8: while open and not ready, the cycle stays open
   assert_hold_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && rdy_n) |=> active_q);
endmodule

// File: rtl/bcd_qualifier.sv
module bcd_qualifier
   import bcd_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start,
   input  logic     wr_rd,
   input  logic     mem_io,
   output bcd_cmd_e cmd_q,
   output bcd_cmd_e cmd_nxt
);
   assign cmd_nxt = start ? bcd_cmd_e'({mem_io, wr_rd}) : cmd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmd_q <= CMD_IORD;
      else        cmd_q <= cmd_nxt;
   end

   // R6: the captured command only changes on a qualifying edge
   assert_cmd_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(cmd_q));
endmodule

// File: rtl/bcd_steer.sv
module bcd_steer
   import bcd_pkg::*;
#(
   parameter bit OUT_REGISTERED = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               active_q,
   input  logic               active_nxt,
   input  bcd_cmd_e           cmd_q,
   input  bcd_cmd_e           cmd_nxt,
   output logic [NUM_CMD-1:0] strobe_n
);
   logic [NUM_CMD-1:0] dec_n;
   logic               sel_act;
   bcd_cmd_e           sel_cmd;

   generate
      if (OUT_REGISTERED) begin : g_sel_next
         assign sel_act = active_nxt;
         assign sel_cmd = cmd_nxt;
      end else begin : g_sel_state
         assign sel_act = active_q;
         assign sel_cmd = cmd_q;
      end
   endgenerate

   // two-way space choice, then direction within the chosen pair
   logic mem_sel, io_sel;
   assign mem_sel = sel_act &&  sel_cmd[CMD_W-1];
   assign io_sel  = sel_act && !sel_cmd[CMD_W-1];

   genvar g;
   generate
      for (g = 0; g < NUM_CMD; g++) begin : g_cmd
         localparam bit SPACE = g[CMD_W-1];
         localparam bit DIR   = g[0];
         assign dec_n[g] = !((SPACE ? mem_sel : io_sel) && (sel_cmd[0] == DIR));
      end
   endgenerate

   generate
      if (OUT_REGISTERED) begin : g_out_ff
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) strobe_n <= '1;
            else        strobe_n <= dec_n;
         end
      end else begin : g_out_comb
         assign strobe_n = dec_n;
      end
   endgenerate

   // R9: never more than one command strobe low
   assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~strobe_n));
endmodule

// File: rtl/bus_cmd_decoder.sv
module bus_cmd_decoder
   import bcd_pkg::*;
#(
   parameter bit OUT_REGISTERED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ads_n,
   input  logic wr_rd,
   input  logic mem_io,
   input  logic rdy_n,
   output logic mem_rd_n,
   output logic mem_wr_n,
   output logic io_rd_n,
   output logic io_wr_n
);
   initial begin
      assert_cmd_count_pow2: assert (NUM_CMD == (1 << CMD_W))
         else $error("command count must be a power of two");
      assert_two_spaces: assert (CMD_W == 2)
         else $error("decoder expects two spaces by two directions");
   end

   logic               start, finish, active_q, active_nxt;
   bcd_cmd_e           cmd_q, cmd_nxt;
   logic [NUM_CMD-1:0] strobe_n;

   bcd_cycle_ctl u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .ads_n      (ads_n),
      .rdy_n      (rdy_n),
      .start      (start),
      .finish     (finish),
      .active_q   (active_q),
      .active_nxt (active_nxt)
   );

   bcd_qualifier u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .wr_rd   (wr_rd),
      .mem_io  (mem_io),
      .cmd_q   (cmd_q),
      .cmd_nxt (cmd_nxt)
   );

   bcd_steer #(.OUT_REGISTERED(OUT_REGISTERED)) u_steer (
      .clk        (clk),
      .rst_n      (rst_n),
      .active_q   (active_q),
      .active_nxt (active_nxt),
      .cmd_q      (cmd_q),
      .cmd_nxt    (cmd_nxt),
      .strobe_n   (strobe_n)
   );

   assign mem_rd_n = strobe_n[CMD_MRD];
   assign mem_wr_n = strobe_n[CMD_MWR];
   assign io_rd_n  = strobe_n[CMD_IORD];
   assign io_wr_n  = strobe_n[CMD_IOWR];

   // R2: opening a cycle drives exactly one strobe low on the next cycle
   assert_one_low_after_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && !ads_n) |=> ($countones({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}) == 3));

   // R6: wait states hold the strobes
   assert_hold_in_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && rdy_n) |=> $stable({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}));

   // R7: ready releases every strobe
   assert_release_on_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !rdy_n) |=> (&{mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}));

   // R10: idle without a strobe request keeps all high
   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && ads_n) |=> (&{mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}));
endmodule

// File: tb/sim_bus_cmd_decoder.sv
module sim_bus_cmd_decoder;
   localparam time CLK_PERIOD = 10ns;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ads_n = 1'b1, wr_rd = 1'b0, mem_io = 1'b0, rdy_n = 1'b1;
   logic mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      int    which;   // 0 io_rd, 1 io_wr, 2 mem_rd, 3 mem_wr
      int    len;
      string tag;
   } exp_t;
   exp_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_cmd_decoder u0 (
      .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .wr_rd(wr_rd), .mem_io(mem_io),
      .rdy_n(rdy_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
      .io_rd_n(io_rd_n), .io_wr_n(io_wr_n)
   );

   function automatic logic [3:0] lows();
      return ~{mem_wr_n, mem_rd_n, io_wr_n, io_rd_n};
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // monitor: measure each strobe pulse and compare with the scoreboard
   int run_len = 0;
   int run_which = -1;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [3:0] l;
         l = lows();
         if ($countones(l) > 1) check(1'b0, "R9 more than one strobe low", int'(l), 0);
         if ($countones(l) == 1) begin
            int w;
            w = (l[0]) ? 0 : (l[1]) ? 1 : (l[2]) ? 2 : 3;
            if (run_len == 0) run_which = w;
            else if (w != run_which) check(1'b0, "R6 strobe changed mid-cycle", w, run_which);
            run_len++;
         end else if (run_len > 0) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R8 unexpected strobe pulse", run_which, -1);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(run_which == e.which, {e.tag, " strobe identity"}, run_which, e.which);
               check(run_len == e.len, {e.tag, " R6 pulse length"}, run_len, e.len);
            end
            run_len = 0;
         end
      end
   end

   // driver: one bus cycle; called at a negative edge
   task automatic do_cycle(input logic wr, input logic mio, input int waits,
                           input bit mid_ads, input bit end_ads, input string tag);
      exp_t e;
      e.which = {mio, wr};
      e.len   = waits + 1;
      e.tag   = tag;
      exp_q.push_back(e);
      ads_n = 1'b0; wr_rd = wr; mem_io = mio; rdy_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < waits; i++) begin
         ads_n = (mid_ads && i == 0) ? 1'b0 : 1'b1;   // R8 mid-cycle strobe
         wr_rd = ~wr; mem_io = ~mio;                    // R6 late status change
         rdy_n = 1'b1;
         @(negedge clk);
      end
      rdy_n = 1'b0;
      ads_n = end_ads ? 1'b0 : 1'b1;                   // R8 strobe on completing edge
      @(negedge clk);
      check(&{mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, {tag, " R7 release after ready"},
            int'(lows()), 0);
      rdy_n = 1'b1; ads_n = 1'b1;
   endtask

   task automatic idle_noise();
      rdy_n = 1'b0; wr_rd = ~wr_rd; mem_io = ~mem_io;
      @(negedge clk);
      check(lows() == 4'b0, "R10 idle ready ignored", int'(lows()), 0);
      rdy_n = 1'b1; wr_rd = ~wr_rd;
      @(negedge clk);
      check(lows() == 4'b0, "R10 idle status change ignored", int'(lows()), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(lows() == 4'b0, "R1 strobes high in reset", int'(lows()), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(lows() == 4'b0, "R1 strobes high after reset", int'(lows()), 0);

      do_cycle(1'b0, 1'b1, 0, 1'b0, 1'b0, "R2 mem read");
      do_cycle(1'b1, 1'b1, 0, 1'b0, 1'b0, "R3 mem write");
      do_cycle(1'b0, 1'b0, 0, 1'b0, 1'b0, "R4 io read");
      do_cycle(1'b1, 1'b0, 0, 1'b0, 1'b0, "R5 io write");
      @(negedge clk);
      do_cycle(1'b0, 1'b1, 4, 1'b0, 1'b0, "R6 mem read waits");
      do_cycle(1'b1, 1'b0, 7, 1'b1, 1'b0, "R8 io write mid strobe");
      do_cycle(1'b1, 1'b1, 2, 1'b1, 1'b1, "R8 mem write end strobe");
      // a strobe on the completing edge must not open a cycle
      check(lows() == 4'b0, "R8 no cycle after completing-edge strobe", int'(lows()), 0);
      idle_noise();
      do_cycle(1'b0, 1'b0, 3, 1'b0, 1'b1, "R4 io read waits");
      @(negedge clk);
      check(lows() == 4'b0, "R8 idle after completing-edge strobe", int'(lows()), 0);
      do_cycle(1'b1, 1'b1, 1, 1'b0, 1'b0, "R3 mem write waits");
      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R8 all queued cycles seen", exp_q.size(), 0);
      check(run_len == 0, "R9 no pulse left open", run_len, 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule